// File: doc/BRIEF.md
# Big-Endian Sub-Word Data Memory

This block is a synchronous data store of 64-bit words that serves loads and stores of 1, 2, 4 or 8 bytes through a single request port. The byte address splits into a word index (upper bits) and a byte offset (lowest three bits). Byte lanes are numbered from the most significant end of the word, so offset 0 names the top byte.

A narrow store is a read-modify-write. Only the addressed lanes take new bytes, and every other byte of the word keeps its value. A narrow load returns the stored word with every byte outside the addressed lanes forced to zero. The selected bytes stay in their lane positions and are not shifted down.

A request whose offset is not a multiple of its size is refused. It changes no storage and raises an error flag in the cycle that carries its result. Every word reads as zero after reset until it is first written.

Top module: `lane_mem`

## Requirements
- R1: The word index is the byte address shifted right by 3, and the byte offset is address bits [2:0]. Accesses to one word never alter any other word.
- R2: A request is aligned only when (offset AND (size_bytes − 1)) is zero. A misaligned request writes nothing. In the next cycle it sets `rd_err` to 1 and `rd_data` to zero. `rd_err` is 0 in every cycle that does not follow a misaligned request.
- R3: Lane numbering is big-endian. An access of w bytes at offset o covers the bits from ((8 − w − o)·8) up to that value plus w·8 − 1. Offset 0 therefore covers the most significant bytes of the word.
- R4: A narrow load returns the stored word ANDed with the lane mask. The bytes stay in place, and every byte outside the lanes reads as zero.
- R5: A narrow store replaces only the addressed lanes, and all other bytes of the word are kept. The store value is taken from the low w·8 bits of `req_wdata`. Higher bits of `req_wdata` are ignored. The most significant of the store bytes goes to the lowest-numbered lane.
- R6: An 8-byte store replaces the whole word. An 8-byte load returns the whole word unmasked.
- R7: After reset every word reads as zero. A narrow store into a word not written since reset merges into zero.
- R8: `rd_data` is registered and shows the result of a request in the cycle after it. A load issued in the cycle right after a store to the same word sees the stored value. A store, or a cycle with no request, produces zero `rd_data` in the next cycle.
- R9: `req_size` encodes the access size as 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes and 3 = 8 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is present this cycle |
| req_we | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W (7) | Byte address |
| req_size | input | 2 | Access size code |
| req_wdata | input | 64 | Store value, right-justified |
| rd_data | output | 64 | Load result, in lane position |
| rd_err | output | 1 | Previous request was misaligned |

## Verification
The bench uses the default geometry: 16 words of 8 bytes, giving 7-bit byte addresses. With this depth the highest word (address 0x7F) and the lowest word can both be reached and shown to be independent. Every size is driven at each of its legal offsets against a byte-wise reference model. Misaligned offsets are driven for every narrow size. Store-then-load pairs are issued back to back on one word to show that the read sees the write.

// File: rtl/lane_mem_pkg.sv
package lane_mem_pkg;
  typedef enum logic [1:0] {
    SZ_B1 = 2'd0,
    SZ_B2 = 2'd1,
    SZ_B4 = 2'd2,
    SZ_B8 = 2'd3
  } acc_size_e;
endpackage

// File: rtl/lane_mem_rst_sync.sv
module lane_mem_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic stage_q;
  logic stage_d;

  always_comb stage_d = 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_n_sync <= 1'b0;
    end else begin
      stage_q    <= stage_d;
      rst_n_sync <= stage_q;
    end
  end
endmodule

// File: rtl/lane_mem_decode.sv
module lane_mem_decode #(
  parameter int WORD_BYTES = 8,
  localparam int OFF_W  = $clog2(WORD_BYTES),
  localparam int DATA_W = WORD_BYTES * 8,
  localparam int SH_W   = OFF_W + 3
) (
  input  logic [OFF_W-1:0]  offset,
  input  logic [1:0]        size,
  output logic              aligned,
  output logic [SH_W-1:0]   lane_shift,
  output logic [DATA_W-1:0] low_mask,
  output logic [DATA_W-1:0] lane_mask
);
  logic [OFF_W:0]   size_bytes;
  logic [OFF_W:0]   gap_bytes;
  logic [OFF_W+3:0] lane_bits;
  logic [OFF_W+3:0] drop_bits;

  always_comb begin
    size_bytes = (OFF_W + 1)'(1) << size;
    aligned    = (offset & size_bytes[OFF_W-1:0] - OFF_W'(1)) == '0;
    if (size_bytes == (OFF_W + 1)'(WORD_BYTES))
      aligned  = (offset == '0);
    gap_bytes  = (OFF_W + 1)'(WORD_BYTES) - size_bytes - {1'b0, offset};
    lane_shift = aligned ? {gap_bytes[OFF_W-1:0], 3'b000} : '0;
    lane_bits  = {size_bytes, 3'b000};
    drop_bits  = (OFF_W + 4)'(DATA_W) - lane_bits;
    low_mask   = {DATA_W{1'b1}} >> drop_bits;
    lane_mask  = low_mask << lane_shift;
  end
endmodule

// File: rtl/lane_mem_store.sv
module lane_mem_store #(
  parameter int WORD_BYTES = 8,
  parameter int DEPTH      = 16,
  localparam int DATA_W = WORD_BYTES * 8,
  localparam int IDX_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wr_word,
  output logic [DATA_W-1:0] rd_word
);
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DEPTH-1:0]  vld_q;
  logic [DEPTH-1:0]  vld_d;

  always_comb begin
    vld_d = vld_q;
    if (wr_en) vld_d[idx] = 1'b1;
    rd_word = vld_q[idx] ? mem_q[idx] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[idx] <= wr_word;
  end

  p_written_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> vld_q[$past(idx)]);
endmodule

// File: rtl/lane_mem.sv
module lane_mem #(
  parameter int WORD_BYTES = 8,
  parameter int DEPTH      = 16,
  localparam int OFF_W  = $clog2(WORD_BYTES),
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int ADDR_W = IDX_W + OFF_W,
  localparam int DATA_W = WORD_BYTES * 8,
  localparam int SH_W   = OFF_W + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_err
);
  logic              rst_n_s;
  logic [IDX_W-1:0]  word_idx;
  logic [OFF_W-1:0]  byte_off;
  logic              aligned;
  logic [SH_W-1:0]   lane_shift;
  logic [DATA_W-1:0] low_mask;
  logic [DATA_W-1:0] lane_mask;
  logic [DATA_W-1:0] cur_word;
  logic [DATA_W-1:0] new_word;
  logic              wr_en;
  logic [DATA_W-1:0] rd_data_d;
  logic              rd_err_d;

  lane_mem_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s));

  always_comb begin
    word_idx = req_addr[ADDR_W-1:OFF_W];
    byte_off = req_addr[OFF_W-1:0];
  end

  lane_mem_decode #(.WORD_BYTES(WORD_BYTES)) u_dec (
    .offset(byte_off), .size(req_size), .aligned(aligned),
    .lane_shift(lane_shift), .low_mask(low_mask), .lane_mask(lane_mask)
  );

  lane_mem_store #(.WORD_BYTES(WORD_BYTES), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n_s), .wr_en(wr_en), .idx(word_idx),
    .wr_word(new_word), .rd_word(cur_word)
  );

  always_comb begin
    wr_en     = req_valid & req_we & aligned;
    new_word  = (cur_word & ~lane_mask) | ((req_wdata & low_mask) << lane_shift);
    rd_data_d = (req_valid & ~req_we & aligned) ? (cur_word & lane_mask) : '0;
    rd_err_d  = req_valid & ~aligned;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      rd_data <= '0;
      rd_err  <= 1'b0;
    end else begin
      rd_data <= rd_data_d;
      rd_err  <= rd_err_d;
    end
  end

  p_err_zero_data_r2: assert property (@(posedge clk) disable iff (!rst_n_s)
    rd_err |-> rd_data == '0);
  p_misalign_flag_r2: assert property (@(posedge clk) disable iff (!rst_n_s)
    (req_valid && !aligned) |=> rd_err);
  p_quiet_idle_r8: assert property (@(posedge clk) disable iff (!rst_n_s)
    !req_valid |=> (rd_data == '0 && !rd_err));
  p_load_in_lane_r4: assert property (@(posedge clk) disable iff (!rst_n_s)
    (req_valid && !req_we && aligned) |=> (rd_data & ~$past(lane_mask)) == '0);
  p_store_no_data_r8: assert property (@(posedge clk) disable iff (!rst_n_s)
    (req_valid && req_we) |=> rd_data == '0);
endmodule

// File: tb/lane_mem_test.sv
module lane_mem_test;
  import lane_mem_pkg::*;

  localparam int WB = 8;
  localparam int DP = 16;
  localparam int AW = 7;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid, req_we;
  logic [AW-1:0] req_addr;
  logic [1:0]    req_size;
  logic [63:0]   req_wdata;
  logic [63:0]   rd_data;
  logic          rd_err;

  int total = 0;
  int bad   = 0;
  logic [63:0] got_d;
  logic        got_e;
  logic [63:0] mdl [DP];

  always #5 clk = ~clk;

  lane_mem #(.WORD_BYTES(WB), .DEPTH(DP)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .rd_data(rd_data), .rd_err(rd_err)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] m_read(logic [AW-1:0] a, logic [1:0] sz);
    logic [63:0] r = '0;
    int w = 1 << sz;
    int o = a[2:0];
    for (int k = o; k < o + w; k++) r[63-8*k -: 8] = mdl[a[AW-1:3]][63-8*k -: 8];
    return r;
  endfunction

  function automatic void m_write(logic [AW-1:0] a, logic [1:0] sz, logic [63:0] v);
    int w = 1 << sz;
    int o = a[2:0];
    for (int j = 0; j < w; j++) mdl[a[AW-1:3]][63-8*(o+j) -: 8] = v[8*(w-1-j) +: 8];
  endfunction

  // called at a falling edge; returns at the next falling edge with the result sampled
  task automatic access(logic we, logic [AW-1:0] a, logic [1:0] sz, logic [63:0] v);
    req_valid = 1'b1; req_we = we; req_addr = a; req_size = sz; req_wdata = v;
    @(negedge clk);
    got_d = rd_data; got_e = rd_err;
  endtask

  task automatic idle();
    req_valid = 1'b0; req_we = 1'b0;
    @(negedge clk);
    got_d = rd_data; got_e = rd_err;
  endtask

  task automatic load_chk(string req, logic [AW-1:0] a, logic [1:0] sz);
    access(1'b0, a, sz, '0);
    chk(req, got_d, m_read(a, sz));
    chk(req, {63'b0, got_e}, 64'd0);
  endtask

  task automatic store(logic [AW-1:0] a, logic [1:0] sz, logic [63:0] v);
    access(1'b1, a, sz, v);
    m_write(a, sz, v);
    chk("R8 store gives zero data", got_d, 64'd0);
  endtask

  task automatic t_reset();
    idle();
    chk("R8 idle data", got_d, 64'd0);
    chk("R2 idle err", {63'b0, got_e}, 64'd0);
    for (int i = 0; i < DP; i++) load_chk("R7 unwritten word", AW'(i * 8), SZ_B8);
  endtask

  task automatic t_full();
    store(7'h08, SZ_B8, 64'h0123_4567_89AB_CDEF);
    load_chk("R6 full load", 7'h08, SZ_B8);
    chk("R6 exact", got_d, 64'h0123_4567_89AB_CDEF);
    load_chk("R1 neighbour word 0 untouched", 7'h00, SZ_B8);
    store(7'h78, SZ_B8, 64'hFEDC_BA98_7654_3210);
    load_chk("R1 top word", 7'h7F & 7'h78, SZ_B8);
    store(7'h08, SZ_B8, 64'h1111_2222_3333_4444);
    load_chk("R6 overwrite", 7'h08, SZ_B8);
  endtask

  task automatic t_lanes();
    store(7'h10, SZ_B8, 64'hA1B2_C3D4_E5F6_0718);
    load_chk("R3 byte lane 0 is MSB", 7'h10, SZ_B1);
    chk("R3 exact", got_d, 64'hA100_0000_0000_0000);
    load_chk("R4 byte lane 7", 7'h17, SZ_B1);
    chk("R4 exact", got_d, 64'h0000_0000_0000_0018);
    for (int s = 0; s < 3; s++)
      for (int o = 0; o < 8; o += (1 << s))
        load_chk("R4 R9 lane load", AW'(8'h10 + o), 2'(s));
    load_chk("R4 half at 2", 7'h12, SZ_B2);
    chk("R4 exact half", got_d, 64'h0000_C3D4_0000_0000);
  endtask

  task automatic t_merge();
    store(7'h19, SZ_B1, 64'hFFFF_FFFF_FFFF_FFAA);
    load_chk("R5 R7 byte into empty word", 7'h18, SZ_B8);
    chk("R5 exact", got_d, 64'h00AA_0000_0000_0000);
    store(7'h1C, SZ_B4, 64'h9999_9999_1234_5678);
    store(7'h1A, SZ_B2, 64'hBEEF);
    load_chk("R5 merged word", 7'h18, SZ_B8);
    chk("R5 exact merged", got_d, 64'h00AA_BEEF_1234_5678);
    for (int s = 0; s < 3; s++)
      for (int o = 0; o < 8; o += (1 << s)) begin
        store(AW'(8'h20 + o), 2'(s), 64'h5A5A_5A5A_0000_0000 | 64'(o * 16 + s + 1));
        load_chk("R5 R3 sweep", 7'h20, SZ_B8);
      end
  endtask

  task automatic t_misalign();
    store(7'h30, SZ_B8, 64'h0F0E_0D0C_0B0A_0908);
    access(1'b1, 7'h32, SZ_B4, 64'hDEAD_BEEF);
    chk("R2 err on misaligned store", {63'b0, got_e}, 64'd1);
    chk("R2 zero data", got_d, 64'd0);
    access(1'b0, 7'h31, SZ_B2, '0);
    chk("R2 err on misaligned load", {63'b0, got_e}, 64'd1);
    chk("R2 zero data load", got_d, 64'd0);
    access(1'b1, 7'h34, SZ_B8, 64'hFFFF_FFFF_FFFF_FFFF);
    chk("R2 err on misaligned full store", {63'b0, got_e}, 64'd1);
    idle();
    chk("R2 err lasts one cycle", {63'b0, got_e}, 64'd0);
    load_chk("R2 word unchanged", 7'h30, SZ_B8);
    chk("R2 exact", got_d, 64'h0F0E_0D0C_0B0A_0908);
  endtask

  task automatic t_b2b();
    store(7'h40, SZ_B8, 64'h0);
    store(7'h45, SZ_B1, 64'h77);
    load_chk("R8 load right after store", 7'h45, SZ_B1);
    chk("R8 exact", got_d, 64'h0000_0000_0077_0000);
    idle();
    chk("R8 idle after load", got_d, 64'd0);
  endtask

  initial begin
    for (int i = 0; i < DP; i++) mdl[i] = '0;
    rst_n = 1'b0; req_valid = 1'b0; req_we = 1'b0;
    req_addr = '0; req_size = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_full();
    t_lanes();
    t_merge();
    t_misalign();
    t_b2b();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1_000_000;
    total++; bad++;
    $display("FAIL watchdog actual=%h expected=%h", 64'd1, 64'd0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule